// File: doc/BRIEF.md
# Piecewise Die Temperature Estimator

This block keeps a running estimate of die temperature after a new hardware configuration has been loaded. Software or a controller loads a starting temperature. From then on, a periodic sampling tick moves the estimate through three stages. First comes a steep warm-up, then a gentler climb, and finally a plateau where only a bounded drift is allowed. Each stage uses a programmable per-tick increment and a programmable end point counted in ticks. The increments are the same for every task mix, so one set of registers serves all configurations.

Two events break the normal sequence. A live configuration change makes the estimate jump at once to the plateau level of the incoming configuration, with no new warm-up. A task removal starts a two-tick cool-down toward a programmable lower level, after which the block rests until the next start. All temperatures are unsigned fixed point in 1/16 °C steps. A typical setup ticks every 30 s, rises about 1.9 °C per tick for 4 ticks, rises 0.5 °C per tick until tick 13, and allows a 2 °C plateau band.

Top module: `die_temp_estimator`

## Requirements
- R1: After synchronous reset, est_temp is 0, phase is 0 (idle) and saturated is 0. The phase codes are idle 0, fast rise 1, slow rise 2, plateau 3, cool-down 4.
- R2: A base_load pulse, in any phase, sets est_temp to base_temp, clears the tick count and sets phase to 1, all visible on the next cycle.
- R3: In phase 1, each tick adds fast_slope to est_temp and counts one tick. The tick that brings the count to fast_ticks or beyond moves phase to 2.
- R4: In phase 2, each tick adds slow_slope. The tick that brings the count to slow_ticks or beyond moves phase to 3 and sets saturated to 1.
- R5: In phase 3, each tick adds creep_step but never lifts est_temp above the plateau reference plus band_width. The reference is the level held on entering phase 3.
- R6: A cfg_change pulse in phase 1, 2 or 3 sets est_temp and the plateau reference to cfg_sat_temp and moves to phase 3 in one cycle, without waiting for a tick.
- R7: A cfg_change pulse in phase 0 or 4 has no effect on any output.
- R8: A task_remove pulse in phase 1, 2 or 3 enters phase 4 with est_temp unchanged. The first tick that follows sets est_temp to floor((est_temp+cool_temp)/2). The second tick sets it to cool_temp and returns phase to 0.
- R9: In phase 0, ticks and task_remove pulses leave every output unchanged.
- R10: Additions saturate at the all-ones value of est_temp and never wrap.
- R11: When several strobes arrive in one cycle, the first applicable one in this order takes effect: base_load, task_remove, cfg_change, tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sampling tick strobe, one cycle |
| base_load | input | 1 | Start strobe; loads base_temp |
| base_temp | input | TEMP_W | Starting temperature, 1/16 °C |
| cfg_change | input | 1 | Live reconfiguration strobe |
| cfg_sat_temp | input | TEMP_W | Plateau level of the incoming configuration |
| task_remove | input | 1 | Task removal strobe |
| cool_temp | input | TEMP_W | Cool-down target level |
| fast_slope | input | STEP_W | Increment per tick in fast rise |
| slow_slope | input | STEP_W | Increment per tick in slow rise |
| creep_step | input | STEP_W | Increment per tick in plateau |
| band_width | input | STEP_W | Allowed plateau rise above the reference |
| fast_ticks | input | CNT_W | Tick count that ends fast rise |
| slow_ticks | input | CNT_W | Tick count that ends slow rise |
| est_temp | output | TEMP_W | Registered temperature estimate |
| phase | output | 3 | Registered phase code |
| saturated | output | 1 | High while in plateau phase |

## Verification
An off-by-one tick counter shows up at the phase output on the tick where a stage should end. The slope then applied to the estimate changes on the very next tick, so a single tick reveals it. A wrong strobe priority or a missing ignore rule changes est_temp or phase one cycle after the strobe, before any tick arrives. A plateau reference captured at the wrong time shows up only after enough drift ticks for the cap to bind, which with the bench values is three ticks into the plateau.

// File: rtl/temp_est_pkg.sv
package temp_est_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_FAST = 3'd1,
    PH_SLOW = 3'd2,
    PH_SAT  = 3'd3,
    PH_COOL = 3'd4
  } phase_t;

  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_JUMP  = 3'd2,
    OP_FAST  = 3'd3,
    OP_SLOW  = 3'd4,
    OP_CREEP = 3'd5,
    OP_CMID  = 3'd6,
    OP_CEND  = 3'd7
  } op_t;

endpackage

// File: rtl/temp_sat_add.sv
module temp_sat_add #(
  parameter int W  = 12,
  parameter int BW = 8
) (
  input  logic [W-1:0]  a,
  input  logic [BW-1:0] b,
  output logic [W-1:0]  y
);
  localparam int SW = W + 1;

  logic [SW-1:0] sum;

  always_comb begin
    sum = {1'b0, a} + SW'(b);
    y   = sum[W] ? {W{1'b1}} : sum[W-1:0];
  end
endmodule

// File: rtl/est_phase_ctrl.sv
module est_phase_ctrl
  import temp_est_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             base_load,
  input  logic             cfg_change,
  input  logic             task_remove,
  input  logic [CNT_W-1:0] fast_ticks,
  input  logic [CNT_W-1:0] slow_ticks,
  output op_t              op,
  output phase_t           phase_q,
  output logic             sat_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  phase_t           phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             half_q, half_d;
  logic             live;

  always_comb begin
    cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    live    = (phase_q == PH_FAST) || (phase_q == PH_SLOW) || (phase_q == PH_SAT);
    op      = OP_HOLD;
    phase_d = phase_q;
    cnt_d   = cnt_q;
    half_d  = half_q;
    if (base_load) begin
      op      = OP_LOAD;
      phase_d = PH_FAST;
      cnt_d   = '0;
    end else if (task_remove && live) begin
      phase_d = PH_COOL;
      half_d  = 1'b0;
    end else if (cfg_change && live) begin
      op      = OP_JUMP;
      phase_d = PH_SAT;
    end else if (tick) begin
      unique case (phase_q)
        PH_FAST: begin
          op    = OP_FAST;
          cnt_d = cnt_inc;
          if (cnt_inc >= fast_ticks) phase_d = PH_SLOW;
        end
        PH_SLOW: begin
          op    = OP_SLOW;
          cnt_d = cnt_inc;
          if (cnt_inc >= slow_ticks) phase_d = PH_SAT;
        end
        PH_SAT: begin
          op    = OP_CREEP;
          cnt_d = cnt_inc;
        end
        PH_COOL: begin
          if (!half_q) begin
            op     = OP_CMID;
            half_d = 1'b1;
          end else begin
            op      = OP_CEND;
            phase_d = PH_IDLE;
          end
        end
        default: op = OP_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      half_q  <= 1'b0;
      sat_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      half_q  <= half_d;
      sat_q   <= (phase_d == PH_SAT);
    end
  end

  // R2: a start pulse always lands in fast rise with a cleared count
  a_r2_load_enters_fast: assert property (@(posedge clk) disable iff (rst)
    base_load |=> (phase_q == PH_FAST) && (cnt_q == '0));

  // R7: reconfiguration outside a live phase leaves the phase alone
  a_r7_cfg_ignored_idle: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE) && cfg_change && !base_load |=> phase_q == PH_IDLE);

  // R8: the second cool-down tick returns to idle
  a_r8_cool_two_ticks: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_COOL) && half_q && tick && !base_load |=> phase_q == PH_IDLE);

  // R4: the flag tracks the plateau phase
  a_r4_flag_matches: assert property (@(posedge clk) disable iff (rst)
    sat_q == (phase_q == PH_SAT));
endmodule

// File: rtl/est_datapath.sv
module est_datapath
  import temp_est_pkg::*;
#(
  parameter int TEMP_W = 12,
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  op_t               op,
  input  phase_t            phase_q,
  input  logic [TEMP_W-1:0] base_temp,
  input  logic [TEMP_W-1:0] cfg_sat_temp,
  input  logic [TEMP_W-1:0] cool_temp,
  input  logic [STEP_W-1:0] fast_slope,
  input  logic [STEP_W-1:0] slow_slope,
  input  logic [STEP_W-1:0] creep_step,
  input  logic [STEP_W-1:0] band_width,
  output logic [TEMP_W-1:0] est_q
);
  localparam int MW = TEMP_W + 1;

  logic [TEMP_W-1:0] ref_q;
  logic [TEMP_W-1:0] add_fast, add_slow, add_creep, cap;
  logic [MW-1:0]     mid_sum;

  temp_sat_add #(.W(TEMP_W), .BW(STEP_W)) u_add_fast  (.a(est_q), .b(fast_slope), .y(add_fast));
  temp_sat_add #(.W(TEMP_W), .BW(STEP_W)) u_add_slow  (.a(est_q), .b(slow_slope), .y(add_slow));
  temp_sat_add #(.W(TEMP_W), .BW(STEP_W)) u_add_creep (.a(est_q), .b(creep_step), .y(add_creep));
  temp_sat_add #(.W(TEMP_W), .BW(STEP_W)) u_add_cap   (.a(ref_q), .b(band_width), .y(cap));

  assign mid_sum = {1'b0, est_q} + {1'b0, cool_temp};

  always_ff @(posedge clk) begin
    if (rst) begin
      est_q <= '0;
      ref_q <= '0;
    end else begin
      unique case (op)
        OP_LOAD: begin
          est_q <= base_temp;
          ref_q <= base_temp;
        end
        OP_JUMP: begin
          est_q <= cfg_sat_temp;
          ref_q <= cfg_sat_temp;
        end
        OP_FAST: est_q <= add_fast;
        OP_SLOW: begin
          est_q <= add_slow;
          ref_q <= add_slow;
        end
        OP_CREEP: est_q <= (add_creep > cap) ? cap : add_creep;
        OP_CMID:  est_q <= mid_sum[MW-1:1];
        OP_CEND:  est_q <= cool_temp;
        default:  est_q <= est_q;
      endcase
    end
  end

  // R5: plateau estimate stays within the band above its reference
  a_r5_band_cap: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_SAT) |-> ({1'b0, est_q} <= {1'b0, ref_q} + MW'(band_width)));

  // R10: rise steps never lower the estimate (no wrap)
  a_r10_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (op == OP_FAST) || (op == OP_SLOW) |=> est_q >= $past(est_q));

  // R9: idle phase with no start pulse keeps the estimate
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE) && (op == OP_HOLD) |=> $stable(est_q));
endmodule

// File: rtl/die_temp_estimator.sv
module die_temp_estimator
  import temp_est_pkg::*;
#(
  parameter int TEMP_W = 12,
  parameter int STEP_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              base_load,
  input  logic [TEMP_W-1:0] base_temp,
  input  logic              cfg_change,
  input  logic [TEMP_W-1:0] cfg_sat_temp,
  input  logic              task_remove,
  input  logic [TEMP_W-1:0] cool_temp,
  input  logic [STEP_W-1:0] fast_slope,
  input  logic [STEP_W-1:0] slow_slope,
  input  logic [STEP_W-1:0] creep_step,
  input  logic [STEP_W-1:0] band_width,
  input  logic [CNT_W-1:0]  fast_ticks,
  input  logic [CNT_W-1:0]  slow_ticks,
  output logic [TEMP_W-1:0] est_temp,
  output logic [2:0]        phase,
  output logic              saturated
);
  op_t    op;
  phase_t phase_q;
  logic   sat_q;

  est_phase_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .base_load(base_load),
    .cfg_change(cfg_change), .task_remove(task_remove),
    .fast_ticks(fast_ticks), .slow_ticks(slow_ticks),
    .op(op), .phase_q(phase_q), .sat_q(sat_q)
  );

  est_datapath #(.TEMP_W(TEMP_W), .STEP_W(STEP_W)) u_dp (
    .clk(clk), .rst(rst), .op(op), .phase_q(phase_q),
    .base_temp(base_temp), .cfg_sat_temp(cfg_sat_temp), .cool_temp(cool_temp),
    .fast_slope(fast_slope), .slow_slope(slow_slope),
    .creep_step(creep_step), .band_width(band_width),
    .est_q(est_temp)
  );

  assign phase     = phase_q;
  assign saturated = sat_q;

  // R6: a live reconfiguration reaches the plateau in one cycle
  a_r6_jump_to_plateau: assert property (@(posedge clk) disable iff (rst)
    cfg_change && !base_load && !task_remove &&
    (phase == 3'd1 || phase == 3'd2 || phase == 3'd3)
    |=> (phase == 3'd3) && (est_temp == $past(cfg_sat_temp)));
endmodule

// File: tb/test_die_temp_estimator.sv
module test_die_temp_estimator;
  localparam int TW = 12;
  localparam int SW = 8;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0, base_load = 1'b0, cfg_change = 1'b0, task_remove = 1'b0;
  logic [TW-1:0] base_temp = 12'd480, cfg_sat_temp = 12'd800, cool_temp = 12'd400;
  logic [SW-1:0] fast_slope = 8'd30, slow_slope = 8'd8, creep_step = 8'd12, band_width = 8'd32;
  logic [CW-1:0] fast_ticks = 8'd4, slow_ticks = 8'd13;
  logic [TW-1:0] est_temp;
  logic [2:0]    phase;
  logic          saturated;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  die_temp_estimator #(.TEMP_W(TW), .STEP_W(SW), .CNT_W(CW)) i_die_temp_estimator (
    .clk(clk), .rst(rst), .tick(tick), .base_load(base_load), .base_temp(base_temp),
    .cfg_change(cfg_change), .cfg_sat_temp(cfg_sat_temp), .task_remove(task_remove),
    .cool_temp(cool_temp), .fast_slope(fast_slope), .slow_slope(slow_slope),
    .creep_step(creep_step), .band_width(band_width), .fast_ticks(fast_ticks),
    .slow_ticks(slow_ticks), .est_temp(est_temp), .phase(phase), .saturated(saturated)
  );

  // op codes: 0 none, 1 tick, 2 base_load, 3 cfg_change, 4 task_remove
  typedef struct packed {
    logic [2:0]  op;
    logic [11:0] est;
    logic [2:0]  ph;
    logic        sat;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [0:NV-1] = '{
    '{3'd2, 12'd480, 3'd1, 1'b0, 4'd2},  // R2 start
    '{3'd1, 12'd510, 3'd1, 1'b0, 4'd3},  // R3 fast rise
    '{3'd1, 12'd540, 3'd1, 1'b0, 4'd3},
    '{3'd1, 12'd570, 3'd1, 1'b0, 4'd3},
    '{3'd1, 12'd600, 3'd2, 1'b0, 4'd3},  // R3 boundary at tick 4
    '{3'd1, 12'd608, 3'd2, 1'b0, 4'd4},  // R4 slow rise
    '{3'd1, 12'd616, 3'd2, 1'b0, 4'd4},
    '{3'd1, 12'd624, 3'd2, 1'b0, 4'd4},
    '{3'd1, 12'd632, 3'd2, 1'b0, 4'd4},
    '{3'd1, 12'd640, 3'd2, 1'b0, 4'd4},
    '{3'd1, 12'd648, 3'd2, 1'b0, 4'd4},
    '{3'd1, 12'd656, 3'd2, 1'b0, 4'd4},
    '{3'd1, 12'd664, 3'd2, 1'b0, 4'd4},
    '{3'd1, 12'd672, 3'd3, 1'b1, 4'd4},  // R4 boundary at tick 13
    '{3'd1, 12'd684, 3'd3, 1'b1, 4'd5},  // R5 creep
    '{3'd1, 12'd696, 3'd3, 1'b1, 4'd5},
    '{3'd1, 12'd704, 3'd3, 1'b1, 4'd5},  // R5 capped at 672+32
    '{3'd1, 12'd704, 3'd3, 1'b1, 4'd5},
    '{3'd4, 12'd704, 3'd4, 1'b0, 4'd8},  // R8 enter cool-down
    '{3'd3, 12'd704, 3'd4, 1'b0, 4'd7},  // R7 ignored in cool-down
    '{3'd0, 12'd704, 3'd4, 1'b0, 4'd8},
    '{3'd1, 12'd552, 3'd4, 1'b0, 4'd8},  // R8 midpoint
    '{3'd1, 12'd400, 3'd0, 1'b0, 4'd8},  // R8 target, back to idle
    '{3'd1, 12'd400, 3'd0, 1'b0, 4'd9},  // R9 idle tick
    '{3'd3, 12'd400, 3'd0, 1'b0, 4'd7},  // R7 ignored in idle
    '{3'd4, 12'd400, 3'd0, 1'b0, 4'd9}   // R9 idle removal
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect3(input string req, input int e_est, input int e_ph, input int e_sat);
    check(req, "est_temp", int'(est_temp), e_est);
    check(req, "phase", int'(phase), e_ph);
    check(req, "saturated", int'(saturated), e_sat);
  endtask

  task automatic drive(input logic lb, input logic tk, input logic cf, input logic rm);
    @(negedge clk);
    base_load = lb; tick = tk; cfg_change = cf; task_remove = rm;
    @(negedge clk);
    base_load = 1'b0; tick = 1'b0; cfg_change = 1'b0; task_remove = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expect3("R1", 0, 0, 0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].op == 3'd2, VECS[i].op == 3'd1, VECS[i].op == 3'd3, VECS[i].op == 3'd4);
      expect3($sformatf("R%0d", VECS[i].req), int'(VECS[i].est), int'(VECS[i].ph), int'(VECS[i].sat));
    end

    // R6: live jump from fast rise, then creep from the new reference
    drive(1, 0, 0, 0);
    drive(0, 1, 0, 0);
    expect3("R6", 510, 1, 0);
    drive(0, 0, 1, 0);
    expect3("R6", 800, 3, 1);
    drive(0, 1, 0, 0);
    expect3("R6", 812, 3, 1);

    // R11: removal beats reconfiguration
    drive(0, 0, 1, 1);
    expect3("R11", 812, 4, 0);
    // R11: start beats removal
    drive(1, 0, 0, 1);
    expect3("R11", 480, 1, 0);
    // R11: reconfiguration beats tick
    drive(0, 1, 1, 0);
    expect3("R11", 800, 3, 1);

    // R10: saturating addition at the top of range
    base_temp = 12'd4090;
    drive(1, 0, 0, 0);
    drive(0, 1, 0, 0);
    expect3("R10", 4095, 1, 0);
    drive(0, 1, 0, 0);
    expect3("R10", 4095, 1, 0);

    // R1: reset in the middle of a run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    expect3("R1", 0, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule